// File: doc/BRIEF.md
# Shared-Multiplier Channel Calibration Sequencer

This block keeps, for every output channel, three host-programmable words: a raw input code, a gain word and an offset word. It turns them into a calibrated code for that channel. Channels are arranged as several equal groups. With the default parameters there are two groups of eight. A per-channel bank-select bit decides whether a channel's result goes to bank A or to bank B. Only one multiplier exists, so the sequencer computes affected channels one at a time. The busy output stays low while results are pending, which tells downstream load logic that the banks are not yet settled.

The host issues single-cycle writes that carry an address mode, a channel number, a register kind and a data word. A write addresses one channel, a whole group, the same position in every group, or every channel. The sequencer marks the addressed channels as pending and works through them in ascending channel order. Each channel occupies one slot. Writes that arrive while it is busy are merged into the pending set.

A rising edge on the re-initialise input restores every register to its default value. It then holds the block busy for a fixed number of cycles, and host writes are discarded during that time. A low level on that input does nothing by itself.

Top module: `chan_cal_seq`

## Requirements
- R1: Address mode (wr_mode) 0 selects channel wr_chan alone. Mode 1 selects every channel in the group of wr_chan (group = wr_chan / GRP_CH). Mode 2 selects the channel at offset wr_chan % GRP_CH in every group. Mode 3 selects all channels.
- R2: Register kind (wr_kind) 0 writes the input word, 1 the gain word and 2 the offset word of each selected channel. Each selected channel's result becomes x × (gain + 1) / 2^DW (truncated) + offset − 2^(DW−1), clamped to 0 .. 2^DW − 1.
- R3: When fmt_twos is high, input and offset data are taken as two's complement, which means bit DW−1 is inverted on storage. The gain word is always straight binary.
- R4: After a write of kind 0..2 that selects n channels from idle, busy_n goes low at the write edge and stays low for SLOT_CYC + SLOT_CYC/2 + n·SLOT_CYC cycles. One done_stb pulse of one cycle is given per channel, channels come in ascending order, and a result register changes only together with its strobe.
- R5: A write accepted while busy_n is low is added to the pending set. The busy time grows by one slot per newly pending channel, and ordering stays ascending.
- R6: Kind 3 loads the bank-select vector from wr_data[NCH−1:0], where bit i = 1 routes channel i to bank B. It holds busy_n low for exactly SLOT_CYC cycles and produces no strobe.
- R7: A rising edge of init_n, after a low level of at least one clock, sets input and offset to 2^(DW−1), gain to all ones, bank-select to zero and both result banks to 2^(DW−1). It then holds busy_n low for RST_CYC cycles. Holding init_n low has no effect.
- R8: Host writes presented during the re-initialise sequence are discarded.
- R9: While rst_n is low and after it is released, busy_n is high and both result banks read 2^(DW−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| init_n | input | 1 | Re-initialise request, acts on rising edge |
| fmt_twos | input | 1 | High: input and offset data are two's complement |
| wr_en | input | 1 | Host write strobe |
| wr_mode | input | 2 | Address mode |
| wr_chan | input | CW | Channel number |
| wr_kind | input | 2 | Register kind |
| wr_data | input | DW | Write data |
| busy_n | output | 1 | Low while results are pending or a timed hold runs |
| x2a_o | output | NCH·DW | Bank A results, channel i at [i·DW +: DW] |
| x2b_o | output | NCH·DW | Bank B results |
| done_stb | output | 1 | One-cycle pulse per finished channel |
| done_chan | output | CW | Channel just finished |
| done_bank | output | 1 | Bank written (1 = B) |

## Verification
A corrupted pending set would show up within one slot as a strobe that is missing or extra, or as channel numbers that are not in ascending order. A wrong busy width shows the fault in the slot counter. A stale or mis-routed gain, offset or bank-select bit appears at the next strobe of that channel as a result word that does not match the reference computed in the bench. A re-initialise that failed to clear state shows up on the first edge after the fire as a result word that is not mid-scale, or as a busy time that is too long.

// File: rtl/cal_pkg.sv
package cal_pkg;
   typedef enum logic [1:0] {
      AM_ONE   = 2'd0,
      AM_GROUP = 2'd1,
      AM_PAIR  = 2'd2,
      AM_ALL   = 2'd3
   } addr_mode_e;

   typedef enum logic [1:0] {
      RK_INPUT   = 2'd0,
      RK_GAIN    = 2'd1,
      RK_OFFS    = 2'd2,
      RK_BANKSEL = 2'd3
   } reg_kind_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_LEAD = 2'd1,
      SQ_CALC = 2'd2
   } seq_state_e;
endpackage

// File: rtl/cal_addr_decode.sv
module cal_addr_decode #(
   parameter int GRP_CH = 8,
   parameter int NGRP   = 2,
   localparam int NCH   = GRP_CH * NGRP,
   localparam int CW    = $clog2(NCH),
   localparam int OW    = $clog2(GRP_CH)
) (
   input  logic [1:0]    mode,
   input  logic [CW-1:0] chan,
   output logic [NCH-1:0] sel
);
   import cal_pkg::*;

   logic [CW-OW-1:0] chan_grp;
   logic [OW-1:0]    chan_off;
   addr_mode_e       am;

   assign chan_grp = chan[CW-1:OW];
   assign chan_off = chan[OW-1:0];
   assign am       = addr_mode_e'(mode);

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      for (genvar k = 0; k < GRP_CH; k++) begin : g_ch
         localparam int IDX = g * GRP_CH + k;
         always_comb begin
            unique case (am)
               AM_ONE:   sel[IDX] = (chan == CW'(IDX));
               AM_GROUP: sel[IDX] = (chan_grp == (CW-OW)'(g));
               AM_PAIR:  sel[IDX] = (chan_off == OW'(k));
               default:  sel[IDX] = 1'b1;
            endcase
         end
      end
   end
endmodule

// File: rtl/cal_mac.sv
module cal_mac #(
   parameter int DW     = 16,
   parameter bit SAT_EN = 1'b1
) (
   input  logic [DW-1:0] x_in,
   input  logic [DW-1:0] gain,
   input  logic [DW-1:0] offs,
   output logic [DW-1:0] y_out
);
   localparam int PW = 2 * DW + 1;
   localparam int SW = DW + 3;
   localparam logic signed [SW-1:0] MID_S  = SW'(1) <<< (DW - 1);
   localparam logic signed [SW-1:0] MAX_S  = (SW'(1) <<< DW) - SW'(1);

   logic [DW:0]            gain_inc;
   logic [PW-1:0]          prod;
   logic [DW-1:0]          scaled;
   logic signed [SW-1:0]   sum;

   assign gain_inc = {1'b0, gain} + (DW+1)'(1);
   assign prod     = PW'(x_in) * PW'(gain_inc);
   assign scaled   = prod[2*DW-1:DW];
   assign sum      = $signed({3'b000, scaled}) + $signed({3'b000, offs}) - MID_S;

   if (SAT_EN) begin : g_sat
      always_comb begin
         if (sum < 0)          y_out = '0;
         else if (sum > MAX_S) y_out = '1;
         else                  y_out = sum[DW-1:0];
      end
   end else begin : g_wrap
      assign y_out = sum[DW-1:0];
   end
endmodule

// File: rtl/cal_init_seq.sv
module cal_init_seq #(
   parameter int RST_CYC = 30000,
   localparam int CNTW   = $clog2(RST_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init_n,
   output logic fire,
   output logic active
);
   logic            s1_q, s2_q;
   logic [CNTW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q <= 1'b1;
         s2_q <= 1'b1;
      end else begin
         s1_q <= init_n;
         s2_q <= s1_q;
      end
   end

   assign fire = s1_q & ~s2_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               cnt_q <= '0;
      else if (fire)            cnt_q <= CNTW'(RST_CYC);
      else if (cnt_q != '0)     cnt_q <= cnt_q - CNTW'(1);
   end

   assign active = (cnt_q != '0);
endmodule

// File: rtl/chan_cal_seq.sv
module chan_cal_seq #(
   parameter int DW       = 16,
   parameter int GRP_CH   = 8,
   parameter int NGRP     = 2,
   parameter int SLOT_CYC = 60,
   parameter int RST_CYC  = 30000,
   parameter bit SAT_EN   = 1'b1,
   localparam int NCH     = GRP_CH * NGRP,
   localparam int CW      = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_n,
   input  logic              fmt_twos,
   input  logic              wr_en,
   input  logic [1:0]        wr_mode,
   input  logic [CW-1:0]     wr_chan,
   input  logic [1:0]        wr_kind,
   input  logic [DW-1:0]     wr_data,
   output logic              busy_n,
   output logic [NCH*DW-1:0] x2a_o,
   output logic [NCH*DW-1:0] x2b_o,
   output logic              done_stb,
   output logic [CW-1:0]     done_chan,
   output logic              done_bank
);
   import cal_pkg::*;

   localparam int LEAD_CYC = SLOT_CYC + SLOT_CYC / 2;
   localparam int TW       = $clog2(LEAD_CYC + 1);
   localparam int AW       = $clog2(SLOT_CYC + 1);
   localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

   if (SLOT_CYC < 2 || (SLOT_CYC % 2) != 0) begin : g_bad_slot
      $error("SLOT_CYC must be even and at least 2");
   end
   if (NCH > DW) begin : g_bad_width
      $error("bank-select vector must fit in one data word");
   end
   if (NGRP < 2 || (NGRP & (NGRP - 1)) != 0 || (GRP_CH & (GRP_CH - 1)) != 0) begin : g_bad_grp
      $error("group count and group size must be powers of two, at least two groups");
   end
   if (RST_CYC < 1) begin : g_bad_rst
      $error("RST_CYC must be positive");
   end

   // re-initialise sequence
   logic init_fire, init_act;

   cal_init_seq #(.RST_CYC(RST_CYC)) init_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .init_n (init_n),
      .fire   (init_fire),
      .active (init_act)
   );

   // host write decode
   logic       acc;
   reg_kind_e  kind;
   logic [NCH-1:0] sel;
   logic [DW-1:0]  fmt_data;

   assign acc      = wr_en & ~init_act & ~init_fire;
   assign kind     = reg_kind_e'(wr_kind);
   assign fmt_data = fmt_twos ? (wr_data ^ MID) : wr_data;

   cal_addr_decode #(.GRP_CH(GRP_CH), .NGRP(NGRP)) dec_i (
      .mode (wr_mode),
      .chan (wr_chan),
      .sel  (sel)
   );

   logic [NCH-1:0] wr_mask;
   assign wr_mask = (acc && kind != RK_BANKSEL) ? sel : '0;

   // sequencer state
   seq_state_e     state_q;
   logic [TW-1:0]  tmr_q;
   logic [NCH-1:0] pend_q, pend_d, done_mask;
   logic [CW-1:0]  pick;
   logic           complete;
   logic [AW-1:0]  ab_tmr_q;
   logic [NCH-1:0] bank_q;

   always_comb begin
      pick = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (pend_q[i]) pick = CW'(i);
      end
   end

   assign complete  = (state_q == SQ_CALC) && (tmr_q == '0);
   assign done_mask = complete ? (NCH'(1) << pick) : '0;
   assign pend_d    = (pend_q & ~done_mask) | wr_mask;

   always_ff @(posedge clk) begin
      if (!rst_n || init_fire) begin
         state_q <= SQ_IDLE;
         tmr_q   <= '0;
         pend_q  <= '0;
      end else begin
         pend_q <= pend_d;
         unique case (state_q)
            SQ_IDLE: begin
               if (wr_mask != '0) begin
                  state_q <= SQ_LEAD;
                  tmr_q   <= TW'(LEAD_CYC - 1);
               end
            end
            SQ_LEAD: begin
               if (tmr_q == '0) begin
                  state_q <= SQ_CALC;
                  tmr_q   <= TW'(SLOT_CYC - 1);
               end else begin
                  tmr_q <= tmr_q - TW'(1);
               end
            end
            SQ_CALC: begin
               if (tmr_q == '0) begin
                  if (pend_d != '0) tmr_q <= TW'(SLOT_CYC - 1);
                  else              state_q <= SQ_IDLE;
               end else begin
                  tmr_q <= tmr_q - TW'(1);
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   // bank-select register and its hold timer
   always_ff @(posedge clk) begin
      if (!rst_n || init_fire) begin
         bank_q   <= '0;
         ab_tmr_q <= '0;
      end else if (acc && kind == RK_BANKSEL) begin
         bank_q   <= wr_data[NCH-1:0];
         ab_tmr_q <= AW'(SLOT_CYC);
      end else if (ab_tmr_q != '0) begin
         ab_tmr_q <= ab_tmr_q - AW'(1);
      end
   end

   // per-channel storage
   logic [DW-1:0] x1_all [NCH];
   logic [DW-1:0] m_all  [NCH];
   logic [DW-1:0] c_all  [NCH];
   logic [DW-1:0] mac_y;

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      logic [DW-1:0] x1_r, m_r, c_r, x2a_r, x2b_r;

      always_ff @(posedge clk) begin
         if (!rst_n || init_fire) begin
            x1_r <= MID;
            m_r  <= '1;
            c_r  <= MID;
         end else if (wr_mask[i]) begin
            unique case (kind)
               RK_INPUT: x1_r <= fmt_data;
               RK_GAIN:  m_r  <= wr_data;
               RK_OFFS:  c_r  <= fmt_data;
               default:  ;
            endcase
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n || init_fire) begin
            x2a_r <= MID;
            x2b_r <= MID;
         end else if (done_mask[i]) begin
            if (bank_q[i]) x2b_r <= mac_y;
            else           x2a_r <= mac_y;
         end
      end

      assign x1_all[i] = x1_r;
      assign m_all[i]  = m_r;
      assign c_all[i]  = c_r;
      assign x2a_o[i*DW +: DW] = x2a_r;
      assign x2b_o[i*DW +: DW] = x2b_r;
   end

   // the single shared multiplier
   cal_mac #(.DW(DW), .SAT_EN(SAT_EN)) mac_i (
      .x_in  (x1_all[pick]),
      .gain  (m_all[pick]),
      .offs  (c_all[pick]),
      .y_out (mac_y)
   );

   // completion strobe
   always_ff @(posedge clk) begin
      if (!rst_n || init_fire) begin
         done_stb  <= 1'b0;
         done_chan <= '0;
         done_bank <= 1'b0;
      end else begin
         done_stb  <= complete;
         if (complete) begin
            done_chan <= pick;
            done_bank <= bank_q[pick];
         end
      end
   end

   assign busy_n = (state_q == SQ_IDLE) && (ab_tmr_q == '0) && !init_act;
endmodule

module cal_seq_chk #(
   parameter int NCH = 16,
   parameter int DW  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_n,
   input logic              done_stb,
   input logic [NCH*DW-1:0] x2a_o,
   input logic [NCH*DW-1:0] x2b_o,
   input logic              init_act,
   input logic              init_fire
);
   localparam logic [NCH*DW-1:0] ALL_MID = {NCH{1'b1, {(DW-1){1'b0}}}};

   // R4
   stb_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_stb |-> $past(!busy_n));

   // R4
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_stb |=> !done_stb);

   // R4
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(x2a_o) || !$stable(x2b_o)) |-> (done_stb || init_act));

   // R7
   init_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_fire |=> (x2a_o == ALL_MID && x2b_o == ALL_MID));

   // R8
   init_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_act |-> !busy_n);
endmodule

bind chan_cal_seq cal_seq_chk #(.NCH(NCH), .DW(DW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy_n    (busy_n),
   .done_stb  (done_stb),
   .x2a_o     (x2a_o),
   .x2b_o     (x2b_o),
   .init_act  (init_act),
   .init_fire (init_fire)
);

// File: tb/chan_cal_seq_tb_top.sv
module chan_cal_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SLOT = 8;
   localparam int RSTC = 50;
   localparam int LEAD = SLOT + SLOT / 2;
   localparam int NCH  = 16;

   typedef struct packed {
      logic        fmt;
      logic [1:0]  mode;
      logic [3:0]  chan;
      logic [1:0]  kind;
      logic [15:0] data;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'd0, 4'd3,  2'd0, 16'h1234},
      '{1'b0, 2'd0, 4'd3,  2'd1, 16'h7FFF},
      '{1'b0, 2'd0, 4'd3,  2'd2, 16'h9000},
      '{1'b0, 2'd1, 4'd9,  2'd0, 16'hC000},
      '{1'b0, 2'd2, 4'd2,  2'd2, 16'hFFFF},
      '{1'b0, 2'd0, 4'd5,  2'd2, 16'h0000},
      '{1'b0, 2'd0, 4'd5,  2'd0, 16'h1000},
      '{1'b0, 2'd0, 4'd0,  2'd3, 16'h00F0},
      '{1'b0, 2'd3, 4'd0,  2'd1, 16'h3FFF},
      '{1'b1, 2'd0, 4'd6,  2'd0, 16'h0000},
      '{1'b1, 2'd1, 4'd0,  2'd2, 16'hF000},
      '{1'b0, 2'd2, 4'd7,  2'd1, 16'h0000}
   };

   logic clk = 1'b0;
   logic rst_n, init_n, fmt_twos, wr_en;
   logic [1:0]  wr_mode, wr_kind;
   logic [3:0]  wr_chan;
   logic [15:0] wr_data;
   logic busy_n, done_stb, done_bank;
   logic [3:0] done_chan;
   logic [NCH*16-1:0] x2a_o, x2b_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   chan_cal_seq #(.SLOT_CYC(SLOT), .RST_CYC(RSTC)) dut_i (
      .clk(clk), .rst_n(rst_n), .init_n(init_n), .fmt_twos(fmt_twos),
      .wr_en(wr_en), .wr_mode(wr_mode), .wr_chan(wr_chan), .wr_kind(wr_kind),
      .wr_data(wr_data), .busy_n(busy_n), .x2a_o(x2a_o), .x2b_o(x2b_o),
      .done_stb(done_stb), .done_chan(done_chan), .done_bank(done_bank)
   );

   int n_chk = 0, n_err = 0;
   bit finished = 0;
   int mx1 [NCH], mm [NCH], mc [NCH], ea [NCH], eb [NCH];
   bit mab [NCH];
   logic [3:0] gch [32];
   logic gbk [32];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int cal(int x, int m, int c);
      longint p, s;
      p = (longint'(x) * longint'(m + 1)) >>> 16;
      s = p + c - 32768;
      if (s < 0) s = 0;
      if (s > 65535) s = 65535;
      return int'(s);
   endfunction

   function automatic bit in_mask(int mode, int chan, int ch);
      case (mode)
         0: return ch == chan;
         1: return (ch / 8) == (chan / 8);
         2: return (ch % 8) == (chan % 8);
         default: return 1'b1;
      endcase
   endfunction

   task automatic model_defaults();
      for (int ch = 0; ch < NCH; ch++) begin
         mx1[ch] = 32768; mm[ch] = 65535; mc[ch] = 32768;
         mab[ch] = 1'b0; ea[ch] = 32768; eb[ch] = 32768;
      end
   endtask

   task automatic model_apply(input vec_t v, output int n);
      int d;
      n = 0;
      d = v.fmt ? int'(v.data ^ 16'h8000) : int'(v.data);
      for (int ch = 0; ch < NCH; ch++) begin
         if (v.kind == 2'd3) mab[ch] = v.data[ch];
         else if (in_mask(v.mode, v.chan, ch)) begin
            if (v.kind == 2'd0) mx1[ch] = d;
            if (v.kind == 2'd1) mm[ch] = int'(v.data);
            if (v.kind == 2'd2) mc[ch] = d;
            if (mab[ch]) eb[ch] = cal(mx1[ch], mm[ch], mc[ch]);
            else         ea[ch] = cal(mx1[ch], mm[ch], mc[ch]);
            n++;
         end
      end
   endtask

   task automatic put(input vec_t v);
      fmt_twos = v.fmt; wr_mode = v.mode; wr_chan = v.chan;
      wr_kind = v.kind; wr_data = v.data; wr_en = 1'b1;
   endtask

   task automatic monitor(input bit first, input vec_t v, input int inj_at, input vec_t v2,
                          input int min_cyc, output int bcnt, output int ns);
      int cyc = 0;
      bcnt = 0; ns = 0;
      if (first) begin @(negedge clk); put(v); end
      forever begin
         @(negedge clk);
         cyc++;
         wr_en = 1'b0;
         if (done_stb) begin
            if (ns < 32) begin gch[ns] = done_chan; gbk[ns] = done_bank; end
            ns++;
         end
         if (!busy_n) bcnt++;
         if (cyc == inj_at) put(v2);
         else if (busy_n && cyc > min_cyc) break;
         if (cyc > 20000) break;
      end
   endtask

   task automatic check_outputs(input string req);
      int bad = -1;
      for (int ch = NCH - 1; ch >= 0; ch--) begin
         if (x2a_o[ch*16 +: 16] != 16'(ea[ch]) || x2b_o[ch*16 +: 16] != 16'(eb[ch])) bad = ch;
      end
      if (bad < 0) check(1'b1, req, 0, 0);
      else if (x2a_o[bad*16 +: 16] != 16'(ea[bad]))
         check(1'b0, {req, " bankA"}, int'(x2a_o[bad*16 +: 16]), ea[bad]);
      else
         check(1'b0, {req, " bankB"}, int'(x2b_o[bad*16 +: 16]), eb[bad]);
   endtask

   // ascending order and bank routing of the recorded strobes
   task automatic check_order(input vec_t v, input vec_t v2, input bit two, input int ns, input string req);
      int k = 0;
      bit ok = 1'b1;
      for (int ch = 0; ch < NCH; ch++) begin
         if (v.kind != 2'd3 && (in_mask(v.mode, v.chan, ch) ||
             (two && in_mask(v2.mode, v2.chan, ch)))) begin
            if (k < ns && k < 32 && (int'(gch[k]) != ch || gbk[k] != mab[ch])) ok = 1'b0;
            k++;
         end
      end
      check(ok && k == ns, req, ns, k);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int bc, ns, n, n2;
      vec_t nv;
      nv = '0;
      rst_n = 1'b0; init_n = 1'b1; fmt_twos = 1'b0; wr_en = 1'b0;
      wr_mode = '0; wr_chan = '0; wr_kind = '0; wr_data = '0;
      model_defaults();
      repeat (4) @(negedge clk);
      // R9: reset state
      check(busy_n == 1'b1, "R9 busy_n in reset", int'(busy_n), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy_n == 1'b1 && done_stb == 1'b0, "R9 idle after reset", int'(busy_n), 1);
      check_outputs("R9 mid-scale banks");

      // R1 R2 R3 R4 R6: table walk
      for (int i = 0; i < NV; i++) begin
         model_apply(VEC[i], n);
         monitor(1'b1, VEC[i], -1, nv, 0, bc, ns);
         check(bc == ((VEC[i].kind == 2'd3) ? SLOT : LEAD + n * SLOT),
               (VEC[i].kind == 2'd3) ? "R6 bank-select busy" : "R4 busy width", bc,
               (VEC[i].kind == 2'd3) ? SLOT : LEAD + n * SLOT);
         check_order(VEC[i], nv, 1'b0, ns, "R1 strobe set and order");
         check_outputs(VEC[i].fmt ? "R3 formatted result" : "R2 result value");
      end

      // R5: second write while busy
      begin
         vec_t a, b;
         a = '{1'b0, 2'd0, 4'd1, 2'd0, 16'h2000};
         b = '{1'b0, 2'd0, 4'd0, 2'd0, 16'h4000};
         model_apply(a, n);
         model_apply(b, n2);
         monitor(1'b1, a, 3, b, 3, bc, ns);
         check(bc == LEAD + 2 * SLOT, "R5 extended busy", bc, LEAD + 2 * SLOT);
         check(ns == 2 && gch[0] == 4'd0 && gch[1] == 4'd1, "R5 queued order",
               int'(gch[0]), 0);
         check_outputs("R5 queued results");
      end

      // R7: low level alone does nothing
      @(negedge clk);
      init_n = 1'b0;
      begin
         int lowbusy = 0;
         repeat (20) begin
            @(negedge clk);
            if (!busy_n) lowbusy++;
         end
         check(lowbusy == 0, "R7 low level no busy", lowbusy, 0);
      end
      check_outputs("R7 low level keeps results");
      init_n = 1'b1;
      // R7 R8: rising edge sequence with a write offered mid-way
      monitor(1'b0, nv, 5, '{1'b0, 2'd3, 4'd0, 2'd0, 16'h0001}, 1, bc, ns);
      model_defaults();
      check(bc == RSTC, "R8 busy exactly reinit time", bc, RSTC);
      check(ns == 0, "R8 no strobe from discarded write", ns, 0);
      check_outputs("R7 defaults restored");

      // R7: gain/offset defaults in effect
      begin
         vec_t a;
         a = '{1'b0, 2'd0, 4'd8, 2'd0, 16'hFFFF};
         model_apply(a, n);
         monitor(1'b1, a, -1, nv, 0, bc, ns);
         check(ns == 1 && gch[0] == 4'd8, "R7 post-default strobe", ns, 1);
         check_outputs("R7 default gain and offset");
      end

      // R7: single-cycle low pulse honoured
      @(negedge clk);
      init_n = 1'b0;
      @(negedge clk);
      init_n = 1'b1;
      monitor(1'b0, nv, -1, nv, 1, bc, ns);
      model_defaults();
      check(bc == RSTC, "R7 short pulse sequence", bc, RSTC);
      check_outputs("R7 short pulse defaults");

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule